// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This block is the add/subtract datapath of a 64-bit integer execution stage. From two register operands, a 16-bit immediate, a 4-bit operation code and the incoming flag state, it forms the 64-bit sum. It also forms the 64-bit and 32-bit carries, the 64-bit and 32-bit signed-overflow bits, a sticky summary-overflow bit and a 4-bit condition field for record forms. Each flag group has its own write-enable, so the surrounding pipeline can merge the flags into its flag register without decoding the operation again.

Subtraction is computed as the inverted A operand plus B plus one. The extended forms replace the constant carry-in with the incoming carry flag. Their B side is the second register, all-ones or zero. The immediate forms use the sign-extended immediate. The shifted-immediate form moves it up by 16 bits. Both add-immediate forms treat a zero register field as the value zero.

An optional output register (parameter `OUT_REG`, default 1) gives exactly one cycle of latency. With `OUT_REG` = 0 the block is purely combinational.

Top module: `int_addsub_flags`

## Requirements
- R1: Operation codes on `op_i` are 0 add (A+B), 1 subtract-from (NOT A + B + 1), 2 add-extended, 3 subtract-from-extended, 4 add-minus-one, 5 subtract-from-minus-one, 6 add-zero, 7 subtract-from-zero, 8 add-immediate, 9 add-immediate-shifted and 10 subtract-from-immediate. `res_o` is the low 64 bits of the sum. Codes 0 and 1 use a carry-in of 0 and 1 respectively.
- R2: Codes 2 to 7 add carry-in `ca_i[0]` to the (possibly inverted) A operand. For codes 2 and 3 the B side is `b_i`, for codes 4 and 5 it is all-ones, and for codes 6 and 7 it is zero.
- R3: `ca_o[0]` is the carry out of bit 63 and `ca_o[1]` is the carry out of bit 31, including carry-in. These bits are written (`ca_we_o`=1) only by codes 2 to 7 and 10. For every other code `ca_we_o`=0 and `ca_o` equals `ca_i`.
- R4: With operands X and Y as actually added (A already inverted for subtract forms), `ov_o[0]` is (carry63 XOR res[63]) AND NOT (X[63] XOR Y[63]). `ov_o[1]` is the same expression on carry31, res[31] and bit 31. These bits are written (`ov_we_o`=1) only when `oe_i`=1 and the code is 0 to 7. Otherwise `ov_o` equals `ov_i`.
- R5: `so_o` is `so_i` OR (`ov_we_o` AND `ov_o[0]`). `so_we_o` equals `ov_we_o`, so the block never clears the bit.
- R6: `cr_o` bit 3 is set for a negative result, bit 2 for a positive nonzero result, bit 1 for a zero result, and bit 0 is a copy of `so_o`. `cr_we_o` is `rc_i` for codes 0 to 7 and 0 for the immediate codes.
- R7: Code 8 adds the sign-extended immediate. Code 9 adds the sign-extended immediate shifted left by 16. For both, `ra_zero_i`=1 forces A to zero, and `ra_zero_i` has no effect on any other code.
- R8: Code 10 computes NOT A + sign-extended immediate + 1 and writes both carry bits from that addition.
- R9: With `OUT_REG`=1 every output follows its inputs one clock later, and a synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| oe_i | input | 1 | Overflow-enable form |
| rc_i | input | 1 | Record form |
| ra_zero_i | input | 1 | A register field is zero (immediate adds only) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| imm_i | input | 16 | Signed immediate |
| ca_i | input | 2 | Incoming carry flags {32-bit, 64-bit} |
| ov_i | input | 2 | Incoming overflow flags {32-bit, 64-bit} |
| so_i | input | 1 | Incoming summary overflow |
| res_o | output | 64 | Result |
| ca_o | output | 2 | Carry flags {32-bit, 64-bit} |
| ca_we_o | output | 1 | Carry flags written |
| ov_o | output | 2 | Overflow flags {32-bit, 64-bit} |
| ov_we_o | output | 1 | Overflow flags written |
| so_o | output | 1 | Summary overflow |
| so_we_o | output | 1 | Summary overflow written |
| cr_o | output | 4 | Condition field {neg, pos, zero, so} |
| cr_we_o | output | 1 | Condition field written |

## Verification
The register forms are swept over a grid of values: zero, one, two, all-ones, the largest positive value and the most negative value, and their neighbours. This grid separates the 64-bit carry from the 64-bit overflow, because a signed wrap and an unsigned wrap occur at different points. A second grid keeps the upper word fixed and moves only across the bit-31 boundary. That isolates the 32-bit carry and overflow from the 64-bit ones. Immediate forms are crossed with the immediate extremes around 0x8000 and with the zero-register flag, which shows whether sign extension, the shift and the A forcing are each applied to the right codes. Random vectors with random flag inputs then show whether the flags are held or written and whether the summary bit stays sticky.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int XLEN     = 64;
    localparam int HALF     = 32;
    localparam int IMM_W    = 16;
    localparam int IMM_SHFT = 16;
    localparam int NSEG     = XLEN / HALF;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUBF   = 4'd1,
        OP_ADDE   = 4'd2,
        OP_SUBFE  = 4'd3,
        OP_ADDME  = 4'd4,
        OP_SUBFME = 4'd5,
        OP_ADDZE  = 4'd6,
        OP_SUBFZE = 4'd7,
        OP_ADDI   = 4'd8,
        OP_ADDIS  = 4'd9,
        OP_SUBFIC = 4'd10
    } addsub_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef enum logic [1:0] {
        BSEL_REG  = 2'd0,
        BSEL_ONES = 2'd1,
        BSEL_ZERO = 2'd2,
        BSEL_IMM  = 2'd3
    } bsel_e;

    typedef struct packed {
        logic     inv_a;
        logic     zero_a_ok;
        bsel_e    bsel;
        logic     imm_shift;
        cin_sel_e cin;
    } opnd_ctl_t;

    typedef struct packed {
        logic wr_ca;
        logic ov_ok;
        logic rc_ok;
    } flag_ctl_t;

    typedef struct packed {
        opnd_ctl_t opnd;
        flag_ctl_t flg;
    } op_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] x;
        logic [XLEN-1:0] y;
        logic            cin;
    } operands_t;

    typedef struct packed {
        logic [XLEN-1:0] sum;
        logic            c64;
        logic            c32;
        logic            v64;
        logic            v32;
    } sum_t;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic [1:0]      ca;
        logic            ca_we;
        logic [1:0]      ov;
        logic            ov_we;
        logic            so;
        logic            so_we;
        logic [3:0]      cr;
        logic            cr_we;
    } unit_out_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic op_ctl_t decode_op(input logic [3:0] op);
        op_ctl_t c;
        c.opnd.inv_a     = 1'b0;
        c.opnd.zero_a_ok = 1'b0;
        c.opnd.bsel      = BSEL_REG;
        c.opnd.imm_shift = 1'b0;
        c.opnd.cin       = CIN_ZERO;
        c.flg.wr_ca      = 1'b0;
        c.flg.ov_ok      = 1'b0;
        c.flg.rc_ok      = 1'b0;
        case (op)
            OP_ADD: begin
                c.flg.ov_ok = 1'b1;
                c.flg.rc_ok = 1'b1;
            end
            OP_SUBF: begin
                c.opnd.inv_a = 1'b1;
                c.opnd.cin   = CIN_ONE;
                c.flg.ov_ok  = 1'b1;
                c.flg.rc_ok  = 1'b1;
            end
            OP_ADDE, OP_SUBFE, OP_ADDME, OP_SUBFME, OP_ADDZE, OP_SUBFZE: begin
                c.opnd.inv_a = op[0];
                c.opnd.cin   = CIN_FLAG;
                c.opnd.bsel  = (op[2:1] == 2'b01) ? BSEL_REG :
                               (op[2:1] == 2'b10) ? BSEL_ONES : BSEL_ZERO;
                c.flg.wr_ca  = 1'b1;
                c.flg.ov_ok  = 1'b1;
                c.flg.rc_ok  = 1'b1;
            end
            OP_ADDI: begin
                c.opnd.zero_a_ok = 1'b1;
                c.opnd.bsel      = BSEL_IMM;
            end
            OP_ADDIS: begin
                c.opnd.zero_a_ok = 1'b1;
                c.opnd.bsel      = BSEL_IMM;
                c.opnd.imm_shift = 1'b1;
            end
            OP_SUBFIC: begin
                c.opnd.inv_a = 1'b1;
                c.opnd.bsel  = BSEL_IMM;
                c.opnd.cin   = CIN_ONE;
                c.flg.wr_ca  = 1'b1;
            end
            default: begin
                c.opnd.cin = CIN_ZERO;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/addsub_operands.sv
module addsub_operands
    import addsub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  opnd_ctl_t        ctl,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             ra_zero_i,
    input  logic             ca_in,
    output operands_t        opnd_o
);

    logic [XLEN-1:0] a_eff;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] imm_val;

    always_comb begin
        a_eff   = (ctl.zero_a_ok && ra_zero_i) ? '0 : a_i;
        imm_ext = sext_imm(imm_i);
        imm_val = ctl.imm_shift ? (imm_ext << IMM_SHFT) : imm_ext;
    end

    always_comb begin
        opnd_o.x = ctl.inv_a ? ~a_eff : a_eff;
        case (ctl.bsel)
            BSEL_REG:  opnd_o.y = b_i;
            BSEL_ONES: opnd_o.y = '1;
            BSEL_ZERO: opnd_o.y = '0;
            default:   opnd_o.y = imm_val;
        endcase
        case (ctl.cin)
            CIN_ONE:  opnd_o.cin = 1'b1;
            CIN_FLAG: opnd_o.cin = ca_in;
            default:  opnd_o.cin = 1'b0;
        endcase
    end

    AST_RA_ZERO_FORCES_A: assert property (@(posedge clk) disable iff (rst)
        (ctl.zero_a_ok && ra_zero_i && !ctl.inv_a) |-> (opnd_o.x == '0)); // R7

    AST_SHIFT_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctl.bsel == BSEL_IMM && ctl.imm_shift) |-> (opnd_o.y[IMM_SHFT-1:0] == '0)); // R7

endmodule

// File: rtl/addsub_core.sv
module addsub_core
    import addsub_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  operands_t opnd_i,
    output sum_t      sum_o
);

    logic [NSEG:0]   cy;
    logic [XLEN-1:0] sum_w;

    assign cy[0] = opnd_i.cin;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [HALF:0] part;
        assign part = {1'b0, opnd_i.x[g*HALF +: HALF]}
                    + {1'b0, opnd_i.y[g*HALF +: HALF]}
                    + {{HALF{1'b0}}, cy[g]};
        assign sum_w[g*HALF +: HALF] = part[HALF-1:0];
        assign cy[g+1]               = part[HALF];
    end

    logic [XLEN-1:0] axb;
    assign axb = opnd_i.x ^ opnd_i.y;

    always_comb begin
        sum_o.sum = sum_w;
        sum_o.c64 = cy[NSEG];
        sum_o.c32 = cy[1];
        sum_o.v64 = (cy[NSEG] ^ sum_w[XLEN-1]) & ~axb[XLEN-1];
        sum_o.v32 = (cy[1] ^ sum_w[HALF-1]) & ~axb[HALF-1];
    end

    AST_FULL_SUM: assert property (@(posedge clk) disable iff (rst)
        {sum_o.c64, sum_o.sum} ==
        ({1'b0, opnd_i.x} + {1'b0, opnd_i.y} + {{XLEN{1'b0}}, opnd_i.cin})); // R3

    AST_OV_SIGNS: assert property (@(posedge clk) disable iff (rst)
        sum_o.v64 |-> (opnd_i.x[XLEN-1] == opnd_i.y[XLEN-1]) &&
                      (sum_o.sum[XLEN-1] != opnd_i.x[XLEN-1])); // R4

    AST_OV32_SIGNS: assert property (@(posedge clk) disable iff (rst)
        sum_o.v32 |-> (opnd_i.x[HALF-1] == opnd_i.y[HALF-1]) &&
                      (sum_o.sum[HALF-1] != opnd_i.x[HALF-1])); // R4

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flag_ctl_t  ctl,
    input  logic       oe_i,
    input  logic       rc_i,
    input  sum_t       sum_i,
    input  logic [1:0] ca_i,
    input  logic [1:0] ov_i,
    input  logic       so_i,
    output unit_out_t  out_o
);

    logic neg, zero, ov_wr;

    always_comb begin
        neg   = sum_i.sum[XLEN-1];
        zero  = (sum_i.sum == '0);
        ov_wr = ctl.ov_ok & oe_i;

        out_o.res   = sum_i.sum;
        out_o.ca_we = ctl.wr_ca;
        out_o.ca    = ctl.wr_ca ? {sum_i.c32, sum_i.c64} : ca_i;
        out_o.ov_we = ov_wr;
        out_o.ov    = ov_wr ? {sum_i.v32, sum_i.v64} : ov_i;
        out_o.so_we = ov_wr;
        out_o.so    = so_i | (ov_wr & sum_i.v64);
        out_o.cr    = {neg, ~neg & ~zero, zero, out_o.so};
        out_o.cr_we = rc_i & ctl.rc_ok;
    end

    AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
        so_i |-> out_o.so); // R5

    AST_CR_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        $onehot(out_o.cr[3:1])); // R6

    AST_OV_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        out_o.ov_we |-> oe_i); // R4

endmodule

// File: rtl/int_addsub_flags.sv
module int_addsub_flags
    import addsub_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op_i,
    input  logic             oe_i,
    input  logic             rc_i,
    input  logic             ra_zero_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [1:0]       ca_i,
    input  logic [1:0]       ov_i,
    input  logic             so_i,
    output logic [XLEN-1:0]  res_o,
    output logic [1:0]       ca_o,
    output logic             ca_we_o,
    output logic [1:0]       ov_o,
    output logic             ov_we_o,
    output logic             so_o,
    output logic             so_we_o,
    output logic [3:0]       cr_o,
    output logic             cr_we_o
);

    op_ctl_t   ctl;
    operands_t opnd;
    sum_t      sum;
    unit_out_t comb_out;
    unit_out_t out;

    assign ctl = decode_op(op_i);

    addsub_operands u_operands (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl.opnd),
        .a_i       (a_i),
        .b_i       (b_i),
        .imm_i     (imm_i),
        .ra_zero_i (ra_zero_i),
        .ca_in     (ca_i[0]),
        .opnd_o    (opnd)
    );

    addsub_core u_core (
        .clk    (clk),
        .rst    (rst),
        .opnd_i (opnd),
        .sum_o  (sum)
    );

    addsub_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl.flg),
        .oe_i  (oe_i),
        .rc_i  (rc_i),
        .sum_i (sum),
        .ca_i  (ca_i),
        .ov_i  (ov_i),
        .so_i  (so_i),
        .out_o (comb_out)
    );

    if (OUT_REG) begin : g_out_reg
        unit_out_t q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= comb_out;
        end
        assign out = q;
    end else begin : g_out_comb
        assign out = comb_out;
    end

    assign res_o   = out.res;
    assign ca_o    = out.ca;
    assign ca_we_o = out.ca_we;
    assign ov_o    = out.ov;
    assign ov_we_o = out.ov_we;
    assign so_o    = out.so;
    assign so_we_o = out.so_we;
    assign cr_o    = out.cr;
    assign cr_we_o = out.cr_we;

    AST_SO_WE_WITH_OV: assert property (@(posedge clk) disable iff (rst)
        so_we_o |-> ov_we_o); // R5

    AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (rst)
        cr_o[0] == so_o); // R6

endmodule

// File: tb/int_addsub_flags_tb.sv
module int_addsub_flags_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic        oe_i = 1'b0, rc_i = 1'b0, ra_zero_i = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [15:0] imm_i = '0;
    logic [1:0]  ca_i = '0, ov_i = '0;
    logic        so_i = 1'b0;
    logic [63:0] res_o;
    logic [1:0]  ca_o, ov_o;
    logic        ca_we_o, ov_we_o, so_o, so_we_o, cr_we_o;
    logic [3:0]  cr_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_addsub_flags #(.OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .oe_i(oe_i), .rc_i(rc_i),
        .ra_zero_i(ra_zero_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
        .ca_i(ca_i), .ov_i(ov_i), .so_i(so_i),
        .res_o(res_o), .ca_o(ca_o), .ca_we_o(ca_we_o), .ov_o(ov_o),
        .ov_we_o(ov_we_o), .so_o(so_o), .so_we_o(so_we_o),
        .cr_o(cr_o), .cr_we_o(cr_we_o)
    );

    // expected values for the vector currently in flight
    logic [63:0] e_res;
    logic [1:0]  e_ca, e_ov;
    logic        e_ca_we, e_ov_we, e_so, e_so_we, e_cr_we;
    logic [3:0]  e_cr;
    logic        pending = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (op %0d)",
                     req, what, act, exp, op_i);
        end
    endtask

    function automatic string res_req(input logic [3:0] op);
        if (op <= 4'd1) return "R1";
        if (op <= 4'd7) return "R2";
        if (op == 4'd10) return "R8";
        return "R7";
    endfunction

    logic [3:0] last_op;

    task automatic compare_all();
        chk(res_req(last_op), "res", res_o, e_res);
        chk((last_op == 4'd10) ? "R8" : "R3", "ca", {62'd0, ca_o}, {62'd0, e_ca});
        chk("R3", "ca_we", {63'd0, ca_we_o}, {63'd0, e_ca_we});
        chk("R4", "ov", {62'd0, ov_o}, {62'd0, e_ov});
        chk("R4", "ov_we", {63'd0, ov_we_o}, {63'd0, e_ov_we});
        chk("R5", "so", {63'd0, so_o}, {63'd0, e_so});
        chk("R5", "so_we", {63'd0, so_we_o}, {63'd0, e_so_we});
        chk("R6", "cr", {60'd0, cr_o}, {60'd0, e_cr});
        chk("R6", "cr_we", {63'd0, cr_we_o}, {63'd0, e_cr_we});
    endtask

    // behavioural reference: wide arithmetic on the effective operands
    task automatic model();
        logic [63:0] xa, yb, aeff, sx;
        logic        cin;
        logic [65:0] full;
        logic [32:0] low;
        logic        c64, c32, v64, v32, ovw;
        aeff = ((op_i == 4'd8 || op_i == 4'd9) && ra_zero_i) ? 64'd0 : a_i;
        sx   = {{48{imm_i[15]}}, imm_i};
        case (op_i)
            4'd0:  begin xa = a_i;  yb = b_i;      cin = 1'b0;    end
            4'd1:  begin xa = ~a_i; yb = b_i;      cin = 1'b1;    end
            4'd2:  begin xa = a_i;  yb = b_i;      cin = ca_i[0]; end
            4'd3:  begin xa = ~a_i; yb = b_i;      cin = ca_i[0]; end
            4'd4:  begin xa = a_i;  yb = '1;       cin = ca_i[0]; end
            4'd5:  begin xa = ~a_i; yb = '1;       cin = ca_i[0]; end
            4'd6:  begin xa = a_i;  yb = '0;       cin = ca_i[0]; end
            4'd7:  begin xa = ~a_i; yb = '0;       cin = ca_i[0]; end
            4'd8:  begin xa = aeff; yb = sx;       cin = 1'b0;    end
            4'd9:  begin xa = aeff; yb = sx << 16; cin = 1'b0;    end
            default: begin xa = ~a_i; yb = sx;     cin = 1'b1;    end
        endcase
        full = {2'b00, xa} + {2'b00, yb} + {65'd0, cin};
        low  = {1'b0, xa[31:0]} + {1'b0, yb[31:0]} + {32'd0, cin};
        c64  = full[64];
        c32  = low[32];
        v64  = (xa[63] == yb[63]) && (full[63] != xa[63]);
        v32  = (xa[31] == yb[31]) && (full[31] != xa[31]);
        ovw  = oe_i && (op_i <= 4'd7);
        e_res   = full[63:0];
        e_ca_we = (op_i >= 4'd2 && op_i <= 4'd7) || op_i == 4'd10;
        e_ca    = e_ca_we ? {c32, c64} : ca_i;
        e_ov_we = ovw;
        e_ov    = ovw ? {v32, v64} : ov_i;
        e_so_we = ovw;
        e_so    = so_i | (ovw & v64);
        e_cr    = {e_res[63], !e_res[63] && e_res != 0, e_res == 0, e_so};
        e_cr_we = rc_i && (op_i <= 4'd7);
    endtask

    task automatic step(input logic [3:0] op, input logic oe, input logic rc,
                        input logic raz, input logic [63:0] a, input logic [63:0] b,
                        input logic [15:0] imm, input logic [1:0] ca,
                        input logic [1:0] ov, input logic so);
        logic [63:0] prev;
        @(negedge clk);
        if (pending) compare_all();
        prev = res_o;
        op_i = op; oe_i = oe; rc_i = rc; ra_zero_i = raz;
        a_i = a; b_i = b; imm_i = imm; ca_i = ca; ov_i = ov; so_i = so;
        model();
        last_op = op;
        pending = 1'b1;
        #1;
        // R9: a new input must not reach the outputs before the next edge
        chk("R9", "latency", res_o, prev);
    endtask

    logic [63:0] v64s [9] = '{64'h0, 64'h1, 64'h2, 64'hFFFFFFFFFFFFFFFF,
        64'hFFFFFFFFFFFFFFFE, 64'h7FFFFFFFFFFFFFFE, 64'h7FFFFFFFFFFFFFFF,
        64'h8000000000000000, 64'h8000000000000001};
    logic [63:0] v32s [9] = '{64'h0, 64'h1, 64'h2, 64'h12345678FFFFFFFF,
        64'h12345678FFFFFFFE, 64'h123456787FFFFFFE, 64'h123456787FFFFFFF,
        64'h1234567880000000, 64'h1234567880000001};
    logic [15:0] imms [9] = '{16'h0, 16'h1, 16'h2, 16'hFFFF, 16'hFFFE,
        16'h8000, 16'h8001, 16'h7FFE, 16'h7FFF};

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset clears every output
        chk("R9", "reset res", res_o, 64'd0);
        chk("R9", "reset flags",
            {50'd0, ca_o, ca_we_o, ov_o, ov_we_o, so_o, so_we_o, cr_o, cr_we_o}, 64'd0);
        rst = 1'b0;

        // R1 R2 R3 R4: register forms over the 64-bit corner grid
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 9; i++)
                for (int j = 0; j < 9; j++)
                    for (int c = 0; c < 2; c++)
                        step(op[3:0], 1'b1, c[0], 1'b0, v64s[i], v64s[j], 16'h0,
                             {1'b0, c[0]}, 2'b00, 1'b0);

        // R3 R4: 32-bit boundary grid, overflow disabled on half the sweep
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 9; i++)
                for (int j = 0; j < 9; j++)
                    step(op[3:0], j[0], 1'b1, 1'b0, v32s[i], v32s[j], 16'h0,
                         {i[0], j[1]}, 2'b11, 1'b0);

        // R7 R8: immediate forms with and without the zero-register flag
        for (int op = 8; op < 11; op++)
            for (int i = 0; i < 9; i++)
                for (int k = 0; k < 9; k++)
                    for (int z = 0; z < 2; z++)
                        step(op[3:0], 1'b1, 1'b1, z[0], v64s[i], 64'hDEAD, imms[k],
                             2'b10, 2'b01, 1'b0);

        // R7: zero-register flag ignored by a register form
        step(4'd0, 1'b0, 1'b0, 1'b1, 64'h5, 64'h7, 16'h0, 2'b00, 2'b00, 1'b0);

        // R5: sticky summary overflow with no new overflow
        step(4'd0, 1'b1, 1'b1, 1'b0, 64'h1, 64'h1, 16'h0, 2'b00, 2'b00, 1'b1);
        step(4'd0, 1'b1, 1'b1, 1'b0, 64'h7FFFFFFFFFFFFFFF, 64'h1, 16'h0, 2'b00, 2'b00, 1'b0);

        // random vectors over all defined codes and flag inputs
        for (int n = 0; n < 3000; n++)
            step(4'($urandom_range(0, 10)), 1'($urandom), 1'($urandom), 1'($urandom),
                 {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom),
                 2'($urandom), 2'($urandom), 1'($urandom));

        @(negedge clk);
        compare_all();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule